// File: doc/BRIEF.md
# Prefixed Bit-Operation ALU

This block performs the arithmetic for the bit-manipulation instruction group of an 8-bit processor, the group that a prefix byte introduces. It is given the operand byte, the second opcode byte and the current flag byte. It returns the new operand value, the new flag byte and a strobe that says whether the result should be written back. Choosing the register, fetching the operand from memory and sequencing the instruction are left to the surrounding core.

The opcode byte is decoded directly. Its two top bits choose the class of operation: shift/rotate, bit test, bit clear or bit set. The middle three bits choose the shift variant, or the bit number for the other classes. The low three bits name the operand source and do not affect this block. All outputs are registered, so each result appears one clock after its inputs are presented.

Flag byte layout: sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2, subtract at bit 1, carry at bit 0. Bits 5 and 3 are unused.

Top module: `bitop_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_q`, `flags_q` and `wb_q` become 0 after that edge.
- R2: Opcode class 00 with variants 0 and 1 rotates circularly. Variant 0 rotates left, moving bit 7 into bit 0. Variant 1 rotates right, moving bit 0 into bit 7.
- R3: Variants 2 and 3 rotate through the carry. Variant 2 rotates left and feeds incoming flag bit 0 into bit 0. Variant 3 rotates right and feeds incoming flag bit 0 into bit 7.
- R4: Variant 4 shifts left with a 0 fill. Variant 5 shifts right and keeps bit 7. Variant 6 shifts left with a 1 fill. Variant 7 shifts right with a 0 fill.
- R5: For the left variants (0, 2, 4, 6) the carry flag becomes operand bit 7. For the right variants (1, 3, 5, 7) it becomes operand bit 0.
- R6: After a shift or rotate, the sign flag is result bit 7 and the zero flag is 1 when the result is 0. The parity flag is 1 when the result has an even number of ones. Flag bits 5, 4, 3 and 1 are 0.
- R7: In class 01 (bit test), the zero flag becomes the complement of the operand bit named by opcode[5:3]. The sign flag becomes operand bit 7 and the subtract flag becomes 0. Flag bits 5, 4, 3, 2 and 0 keep their incoming values. The result equals the operand.
- R8: Class 10 clears and class 11 sets the operand bit named by opcode[5:3]. All other operand bits are unchanged, and the flag byte passes through unchanged.
- R9: `wb_q` is 0 for class 01 and 1 for classes 00, 10 and 11.
- R10: opcode[2:0] has no effect on any output.
- R11: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 8 | Operand byte |
| opc_i | input | 8 | Second opcode byte: class [7:6], variant or bit index [5:3], operand code [2:0] |
| flags_i | input | 8 | Incoming flag byte |
| res_q | output | 8 | Registered result byte |
| flags_q | output | 8 | Registered flag byte |
| wb_q | output | 1 | Registered write-back enable |

## Verification
The properties compare each registered output with the inputs one cycle earlier. They therefore assume that the inputs are known, stable values on every sampled edge once reset is released, and they only become active after one full cycle out of reset. The bench changes the inputs only on falling edges and holds them through the next rising edge. It sweeps every opcode against a set of operand patterns, with the incoming carry both clear and set, so every class and variant is exercised under the conditions the properties rely on.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_W  = 8;
  localparam int SEL_W   = 3;

  localparam int FL_SIGN = 7;
  localparam int FL_ZERO = 6;
  localparam int FL_HALF = 4;
  localparam int FL_PAR  = 2;
  localparam int FL_SUB  = 1;
  localparam int FL_CARRY = 0;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLR   = 2'b10,
    CLS_SET   = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    SV_ROT_L   = 3'd0,
    SV_ROT_R   = 3'd1,
    SV_ROTC_L  = 3'd2,
    SV_ROTC_R  = 3'd3,
    SV_ASH_L   = 3'd4,
    SV_ASH_R   = 3'd5,
    SV_ONES_L  = 3'd6,
    SV_LSH_R   = 3'd7
  } shift_var_e;

  function automatic logic even_parity(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/bitop_shift_unit.sv
module bitop_shift_unit
  import bitop_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] variant,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);
  logic msb, lsb;
  logic left_dir;

  assign msb      = din[W-1];
  assign lsb      = din[0];
  assign left_dir = ~variant[0];
  assign cout     = left_dir ? msb : lsb;

  always_comb begin
    unique case (shift_var_e'(variant))
      SV_ROT_L:  dout = {din[W-2:0], msb};
      SV_ROT_R:  dout = {lsb, din[W-1:1]};
      SV_ROTC_L: dout = {din[W-2:0], cin};
      SV_ROTC_R: dout = {cin, din[W-1:1]};
      SV_ASH_L:  dout = {din[W-2:0], 1'b0};
      SV_ASH_R:  dout = {msb, din[W-1:1]};
      SV_ONES_L: dout = {din[W-2:0], 1'b1};
      default:   dout = {1'b0, din[W-1:1]};
    endcase
  end
endmodule

// File: rtl/bitop_bit_unit.sv
module bitop_bit_unit
  import bitop_pkg::*;
#(
  parameter int W = DATA_W,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     cleared,
  output logic [W-1:0]     setted,
  output logic             picked
);
  logic [W-1:0] mask;
  logic [W-1:0] hit;

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign mask[g] = (idx == IDX_W'(g));
    assign hit[g]  = mask[g] & din[g];
  end

  assign cleared = din & ~mask;
  assign setted  = din | mask;
  assign picked  = |hit;
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opnd_i,
  input  logic [7:0]    opc_i,
  input  logic [FW-1:0] flags_i,
  output logic [W-1:0]  res_q,
  output logic [FW-1:0] flags_q,
  output logic          wb_q
);
  localparam int IDX_W = $clog2(W);

  op_class_e        cls;
  logic [SEL_W-1:0] sel;

  logic [W-1:0]  sh_res;
  logic          sh_cout;
  logic [W-1:0]  clr_res, set_res;
  logic          bit_val;

  logic [W-1:0]  res_d;
  logic [FW-1:0] flags_d;
  logic          wb_d;

  assign cls = op_class_e'(opc_i[7:6]);
  assign sel = opc_i[5:3];

  bitop_shift_unit #(.W(W)) u_shift (
    .din     (opnd_i),
    .variant (sel),
    .cin     (flags_i[FL_CARRY]),
    .dout    (sh_res),
    .cout    (sh_cout)
  );

  bitop_bit_unit #(.W(W)) u_bit (
    .din     (opnd_i),
    .idx     (sel[IDX_W-1:0]),
    .cleared (clr_res),
    .setted  (set_res),
    .picked  (bit_val)
  );

  always_comb begin
    res_d   = opnd_i;
    flags_d = flags_i;
    wb_d    = 1'b1;
    unique case (cls)
      CLS_SHIFT: begin
        res_d              = sh_res;
        flags_d            = '0;
        flags_d[FL_SIGN]   = sh_res[W-1];
        flags_d[FL_ZERO]   = (sh_res == '0);
        flags_d[FL_PAR]    = even_parity(sh_res);
        flags_d[FL_CARRY]  = sh_cout;
      end
      CLS_TEST: begin
        wb_d               = 1'b0;
        flags_d[FL_SIGN]   = opnd_i[W-1];
        flags_d[FL_ZERO]   = ~bit_val;
        flags_d[FL_SUB]    = 1'b0;
      end
      CLS_CLR: res_d = clr_res;
      default: res_d = set_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
      wb_q    <= 1'b0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      wb_q    <= wb_d;
    end
  end
endmodule

// File: rtl/bitop_alu_chk.sv
module bitop_alu_chk
  import bitop_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] opnd_i,
  input logic [7:0] opc_i,
  input logic [7:0] flags_i,
  input logic [7:0] res_q,
  input logic [7:0] flags_q,
  input logic       wb_q
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res_q == 8'h00 && flags_q == 8'h00 && !wb_q)); // R1

  AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (rst || !armed)
    (wb_q == ($past(opc_i[7:6]) != 2'b01))); // R9

  AST_TEST_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(opc_i[7:6]) == 2'b01) |-> (res_q == $past(opnd_i)
      && flags_q[0] == $past(flags_i[0]) && !flags_q[1])); // R7

  AST_SETCLR_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(opc_i[7]) == 1'b1) |-> (flags_q == $past(flags_i))); // R8

  AST_SETCLR_ONE_BIT: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(opc_i[7]) == 1'b1) |-> ($countones(res_q ^ $past(opnd_i)) <= 1)); // R8

  AST_SHIFT_CLEAR_HN: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(opc_i[7:6]) == 2'b00) |-> (!flags_q[4] && !flags_q[1]
      && flags_q[6] == (res_q == 8'h00))); // R6

  AST_SHIFT_CARRY_SRC: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(opc_i[7:6]) == 2'b00) |-> (flags_q[0] ==
      ($past(opc_i[3]) ? $past(opnd_i[0]) : $past(opnd_i[7])))); // R5
endmodule

bind bitop_alu bitop_alu_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .opnd_i  (opnd_i),
  .opc_i   (opc_i),
  .flags_i (flags_i),
  .res_q   (res_q),
  .flags_q (flags_q),
  .wb_q    (wb_q)
);

// File: tb/bitop_alu_tb.sv
module bitop_alu_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] opnd_i, opc_i, flags_i;
  logic [7:0] res_q, flags_q;
  logic       wb_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitop_alu u_dut (
    .clk(clk), .rst(rst), .opnd_i(opnd_i), .opc_i(opc_i), .flags_i(flags_i),
    .res_q(res_q), .flags_q(flags_q), .wb_q(wb_q)
  );

  logic [7:0] e_res, e_flg;
  logic       e_wb;

  task automatic model(input logic [7:0] a, input logic [7:0] op, input logic [7:0] f);
    logic [2:0] s;
    logic c;
    s = op[5:3];
    c = f[0];
    e_res = a; e_flg = f; e_wb = 1'b1;
    case (op[7:6])
      2'b00: begin
        case (s)
          3'd0: e_res = (a << 1) | (a >> 7);              // R2
          3'd1: e_res = (a >> 1) | (a << 7);              // R2
          3'd2: e_res = (a << 1) | {7'd0, c};             // R3
          3'd3: e_res = (a >> 1) | {c, 7'd0};             // R3
          3'd4: e_res = a << 1;                           // R4
          3'd5: e_res = (a >> 1) | (a & 8'h80);           // R4
          3'd6: e_res = (a << 1) | 8'h01;                 // R4
          default: e_res = a >> 1;                        // R4
        endcase
        e_flg = 8'h00;
        e_flg[7] = e_res[7];
        e_flg[6] = (e_res == 0);
        e_flg[2] = ($countones(e_res) % 2 == 0);
        e_flg[0] = s[0] ? a[0] : a[7];                    // R5
      end
      2'b01: begin
        e_wb = 1'b0;
        e_flg[7] = a[7];
        e_flg[6] = ((a >> s) & 8'h01) == 0;
        e_flg[1] = 1'b0;
      end
      2'b10: e_res = a & ~(8'h01 << s);
      default: e_res = a | (8'h01 << s);
    endcase
  endtask

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] a, input logic [7:0] op, input logic [7:0] f);
    string tr, tf;
    opnd_i = a; opc_i = op; flags_i = f;
    @(negedge clk);
    model(a, op, f);
    case (op[7:6])
      2'b00: begin tr = "R2/R3/R4 result"; tf = "R5/R6 flags"; end
      2'b01: begin tr = "R7 result"; tf = "R7 flags"; end
      default: begin tr = "R8 result"; tf = "R8 flags"; end
    endcase
    chk(tr, {1'b0, res_q}, {1'b0, e_res});
    chk(tf, {1'b0, flags_q}, {1'b0, e_flg});
    chk("R9 wb", {8'd0, wb_q}, {8'd0, e_wb});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [8];
    logic [7:0] r0, f0;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80; pats[3] = 8'h01;
    pats[4] = 8'hA5; pats[5] = 8'h5A; pats[6] = 8'h7E; pats[7] = 8'h3C;
    rst = 1'b1; opnd_i = 8'hFF; opc_i = 8'hFF; flags_i = 8'hFF;
    @(negedge clk); @(negedge clk);
    // R1: reset clears all outputs
    chk("R1 res", {1'b0, res_q}, 9'h000);
    chk("R1 flags", {1'b0, flags_q}, 9'h000);
    chk("R1 wb", {8'd0, wb_q}, 9'h000);
    rst = 1'b0;

    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 256; k++)
        for (int cf = 0; cf < 2; cf++)
          run_one(pats[p], 8'(k), cf[0] ? 8'hD7 : 8'h28);

    // R10: operand code field has no effect
    for (int k = 0; k < 32; k++) begin
      opnd_i = 8'h96; opc_i = {k[4:0], 3'b000}; flags_i = 8'h15;
      @(negedge clk);
      r0 = res_q; f0 = flags_q;
      opc_i = {k[4:0], 3'b111};
      @(negedge clk);
      chk("R10 res", {1'b0, res_q}, {1'b0, r0});
      chk("R10 flags", {1'b0, flags_q}, {1'b0, f0});
    end

    // R11: outputs hold until the next rising edge
    opnd_i = 8'h01; opc_i = 8'hC0 | (3'd7 << 3); flags_i = 8'h00;
    @(negedge clk);
    opnd_i = 8'h00; opc_i = 8'h00;
    #5;
    chk("R11 hold", {1'b0, res_q}, 9'h081);
    @(negedge clk);
    chk("R11 update", {1'b0, res_q}, 9'h000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule